// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 32-bit program counter of a simple in-order core and works out, each cycle, where the next fetch comes from. It looks at the current instruction word and the two register operand values read for it. From these it picks one of four next addresses: the following word, a PC-relative conditional branch target, a region-preserving absolute jump target, or an address taken from a register. The counter moves only on cycles where the step enable is high.

For a call, the unit raises a link-write request to the register file. The request names register 31 and carries the address of the instruction after the call. A taken flag marks every step in which the fetch stream is redirected away from sequential flow. Instruction memory, the register file, prediction and delay slots lie outside the block.

Top module: `pc_next_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0, and it stays 0 until the first enabled step after reset is released.
- R2: When step_i is low, pc_o keeps its value, and taken_o and link_we_o are 0, whatever the instruction.
- R3: Any instruction that is not a branch, jump or jr advances pc_o by 4 on a step, with taken_o low. This includes opcode 0 with a funct other than 8.
- R4: Opcode 4 (bits 31:26) is branch-if-equal. When rs_val_i equals rt_val_i, the next PC is PC + 4 + 4 × offset, where offset is bits 15:0. An offset of 25 therefore lands 100 bytes past PC + 4. Otherwise the next PC is PC + 4.
- R5: Opcode 5 is branch-if-not-equal. It uses the same target as R4, but it is taken only when rs_val_i and rt_val_i differ.
- R6: The 16-bit branch offset is treated as signed, so a negative offset moves the PC backwards.
- R7: Opcode 2 is a jump. The next PC is built from the top 4 bits of PC + 4, then the 26-bit field in bits 25:0, then two zero bits. A field of 2500 thus reaches byte 10000 inside the current 256 MB region.
- R8: Opcode 3 is a call. It jumps as in R7. During the same step it drives link_we_o high with link_addr_o = 31 and link_data_o = PC + 4.
- R9: Opcode 0 with funct 8 (bits 5:0) sets the next PC to rs_val_i.
- R10: taken_o is high on a step exactly when the next PC comes from a taken branch, a jump, a call or jr. link_we_o is high only for a call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance the PC this cycle |
| instr_i | input | 32 | Instruction at the current PC |
| rs_val_i | input | 32 | First register operand value |
| rt_val_i | input | 32 | Second register operand value |
| pc_o | output | 32 | Current program counter |
| taken_o | output | 1 | Redirect from sequential flow this step |
| link_we_o | output | 1 | Link register write request |
| link_addr_o | output | 5 | Link register index (31) |
| link_data_o | output | 32 | Return address, PC + 4 |

## Verification
Assertions check, on every cycle, the following invariants: the PC holds while the step enable is low, sequential steps add exactly 4, jump and call targets are word aligned and stay in the region of PC + 4, and a link request always carries PC + 4 together with a redirect. Only the bench scenarios can show that the branch arithmetic is right, including the sign of a negative offset and the exact byte 10000 for a jump field of 2500. The same holds for the equal/not-equal decisions on chosen operand pairs and for jr following an arbitrary register value. The bench compares every step against a behavioural model driven by fixed cases and a long pseudo-random instruction stream.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned OP_W     = 6;
  localparam int unsigned FUNCT_W  = 6;
  localparam int unsigned OFFSET_W = 16;
  localparam int unsigned INDEX_W  = 26;
  localparam int unsigned REG_W    = 5;

  localparam logic [OP_W-1:0]    OP_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0]    OP_JUMP    = 6'd2;
  localparam logic [OP_W-1:0]    OP_CALL    = 6'd3;
  localparam logic [OP_W-1:0]    OP_BR_EQ   = 6'd4;
  localparam logic [OP_W-1:0]    OP_BR_NE   = 6'd5;
  localparam logic [FUNCT_W-1:0] FN_REGJMP  = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BR_EQ,
    FLOW_BR_NE,
    FLOW_JUMP,
    FLOW_CALL,
    FLOW_REG
  } flow_e;
endpackage

// File: rtl/pc_decode.sv
module pc_decode
  import pc_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic [IW-1:0]       instr_i,
  output flow_e               flow_o,
  output logic [OFFSET_W-1:0] offset_o,
  output logic [INDEX_W-1:0]  index_o
);
  localparam int unsigned OP_LSB = IW - OP_W;

  logic [OP_W-1:0]    opcode;
  logic [FUNCT_W-1:0] funct;

  assign opcode   = instr_i[IW-1:OP_LSB];
  assign funct    = instr_i[FUNCT_W-1:0];
  assign offset_o = instr_i[OFFSET_W-1:0];
  assign index_o  = instr_i[INDEX_W-1:0];

  always_comb begin
    unique case (opcode)
      OP_BR_EQ:   flow_o = FLOW_BR_EQ;
      OP_BR_NE:   flow_o = FLOW_BR_NE;
      OP_JUMP:    flow_o = FLOW_JUMP;
      OP_CALL:    flow_o = FLOW_CALL;
      OP_SPECIAL: flow_o = (funct == FN_REGJMP) ? FLOW_REG : FLOW_SEQ;
      default:    flow_o = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/pc_cond.sv
module pc_cond
  import pc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  flow_e         flow_i,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  output logic          redirect_o
);
  logic same;

  assign same = (op_a_i == op_b_i);

  always_comb begin
    unique case (flow_i)
      FLOW_BR_EQ: redirect_o = same;
      FLOW_BR_NE: redirect_o = !same;
      FLOW_JUMP,
      FLOW_CALL,
      FLOW_REG:   redirect_o = 1'b1;
      default:    redirect_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_target.sv
module pc_target
  import pc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [AW-1:0]       pc_i,
  input  logic [OFFSET_W-1:0] offset_i,
  input  logic [INDEX_W-1:0]  index_i,
  output logic [AW-1:0]       seq_o,
  output logic [AW-1:0]       branch_o,
  output logic [AW-1:0]       jump_o
);
  localparam int unsigned ALIGN_W  = $clog2(WORD_BYTES);
  localparam int unsigned REGION_W = AW - INDEX_W - ALIGN_W;
  localparam int unsigned EXT_W    = AW - OFFSET_W - ALIGN_W;

  logic [AW-1:0] disp;

  assign seq_o    = pc_i + AW'(WORD_BYTES);
  assign disp     = {{EXT_W{offset_i[OFFSET_W-1]}}, offset_i, {ALIGN_W{1'b0}}};
  assign branch_o = seq_o + disp;
  assign jump_o   = {seq_o[AW-1 -: REGION_W], index_i, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_pkg::*;
#(
  parameter int unsigned AW       = XLEN,
  parameter int unsigned LINK_REG = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [XLEN-1:0]  instr_i,
  input  logic [AW-1:0]    rs_val_i,
  input  logic [AW-1:0]    rt_val_i,
  output logic [AW-1:0]    pc_o,
  output logic             taken_o,
  output logic             link_we_o,
  output logic [REG_W-1:0] link_addr_o,
  output logic [AW-1:0]    link_data_o
);
  localparam int unsigned REGION_W = 4;

  flow_e               flow;
  logic [OFFSET_W-1:0] offset;
  logic [INDEX_W-1:0]  index;
  logic                redirect;
  logic [AW-1:0]       seq_pc, br_pc, jmp_pc, pc_d, pc_q;

  pc_decode #(.IW(XLEN)) u_decode (
    .instr_i  (instr_i),
    .flow_o   (flow),
    .offset_o (offset),
    .index_o  (index)
  );

  pc_cond #(.DW(AW)) u_cond (
    .flow_i     (flow),
    .op_a_i     (rs_val_i),
    .op_b_i     (rt_val_i),
    .redirect_o (redirect)
  );

  pc_target #(.AW(AW), .WORD_BYTES(4)) u_target (
    .pc_i     (pc_q),
    .offset_i (offset),
    .index_i  (index),
    .seq_o    (seq_pc),
    .branch_o (br_pc),
    .jump_o   (jmp_pc)
  );

  always_comb begin
    pc_d = seq_pc;
    if (redirect) begin
      unique case (flow)
        FLOW_BR_EQ, FLOW_BR_NE: pc_d = br_pc;
        FLOW_JUMP, FLOW_CALL:   pc_d = jmp_pc;
        FLOW_REG:               pc_d = rs_val_i;
        default:                pc_d = seq_pc;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (step_i) pc_q <= pc_d;
  end

  assign pc_o        = pc_q;
  assign taken_o     = step_i & redirect;
  assign link_we_o   = step_i & (flow == FLOW_CALL);
  assign link_addr_o = REG_W'(LINK_REG);
  assign link_data_o = seq_pc;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o));

  assert_seq_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !taken_o) |=> (pc_o == $past(pc_o) + AW'(4)));

  assert_jump_region_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (flow == FLOW_JUMP || flow == FLOW_CALL)) |=>
      (pc_o[1:0] == 2'b00 &&
       pc_o[AW-1 -: REGION_W] == $past(link_data_o[AW-1 -: REGION_W])));

  assert_link_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (taken_o && link_data_o == pc_o + AW'(4) && link_addr_o == REG_W'(LINK_REG)));

  assert_taken_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o || link_we_o) |-> step_i);
endmodule

// File: tb/pc_next_unit_tb_top.sv
module pc_next_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] pc_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_addr_o;
  logic [31:0] link_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m_pc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_next_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .instr_i(instr_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .pc_o(pc_o), .taken_o(taken_o),
    .link_we_o(link_we_o), .link_addr_o(link_addr_o), .link_data_o(link_data_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_i(input int op, input int rs, input int rt, input int low16);
    return {op[5:0], rs[4:0], rt[4:0], low16[15:0]};
  endfunction

  function automatic logic [31:0] mk_j(input int op, input int idx);
    return {op[5:0], idx[25:0]};
  endfunction

  // behavioural reference: next pc, taken, link request
  task automatic model(input logic [31:0] pc, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input bit en,
                       output logic [31:0] npc, output bit tk, output bit lw);
    int op, fn;
    logic [31:0] pc4;
    op = int'(ins[31:26]);
    fn = int'(ins[5:0]);
    pc4 = pc + 32'd4;
    npc = pc4; tk = 0; lw = 0;
    if ((op == 4 && a == b) || (op == 5 && a != b)) begin
      npc = pc4 + 32'($signed(ins[15:0]) * 4);
      tk = 1;
    end else if (op == 2 || op == 3) begin
      npc = (pc4 & 32'hF000_0000) | (32'(ins[25:0]) * 32'd4);
      tk = 1;
      lw = (op == 3);
    end else if (op == 0 && fn == 8) begin
      npc = a;
      tk = 1;
    end
    if (!en) begin
      npc = pc; tk = 0; lw = 0;
    end
  endtask

  task automatic do_step(input string req, input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input bit en);
    logic [31:0] npc;
    bit tk, lw;
    @(negedge clk);
    instr_i = ins; rs_val_i = a; rt_val_i = b; step_i = en;
    model(m_pc, ins, a, b, en, npc, tk, lw);
    #1;
    chk(req, "taken_o", {31'd0, taken_o}, {31'd0, tk});
    chk("R10", "link_we_o", {31'd0, link_we_o}, {31'd0, lw});
    if (lw) begin
      chk("R8", "link_addr_o", {27'd0, link_addr_o}, 32'd31);
      chk("R8", "link_data_o", link_data_o, m_pc + 32'd4);
    end
    @(posedge clk);
    #1;
    chk(req, "pc_o", pc_o, npc);
    m_pc = npc;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "pc_o in reset", pc_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "pc_o after release", pc_o, 32'd0);

    do_step("R3", 32'h0000_0020, 1, 2, 1);                 // add-type, funct 0x20
    do_step("R3", mk_i(8, 1, 2, 5), 0, 0, 1);              // other opcode
    do_step("R4", mk_i(4, 1, 2, 25), 32'h55, 32'h55, 1);   // taken, +100 past pc+4
    do_step("R4", mk_i(4, 1, 2, 25), 32'h55, 32'h56, 1);   // not taken
    do_step("R5", mk_i(5, 1, 2, 3), 7, 9, 1);              // taken
    do_step("R5", mk_i(5, 1, 2, 3), 9, 9, 1);              // not taken
    do_step("R6", mk_i(4, 0, 0, 16'hFFF0), 0, 0, 1);       // offset -16
    do_step("R9", 32'h03E0_0008, 32'h3000_0040, 0, 1);     // jr to region 3
    do_step("R7", mk_j(2, 2500), 0, 0, 1);                 // -> 0x3000_2710
    chk("R7", "region jump byte 10000", m_pc, 32'h3000_2710);
    do_step("R8", mk_j(3, 26'h3FF_FFFF), 0, 0, 1);         // call
    do_step("R2", mk_j(2, 100), 0, 0, 0);                  // held
    do_step("R2", 32'h03E0_0008, 32'h1234_5678, 0, 0);     // held
    do_step("R3", 32'h0000_0009, 32'h1234_5678, 0, 1);     // funct 9 is sequential
    do_step("R9", 32'h0000_0008, 32'hFFFF_FFFC, 0, 1);     // jr to top
    do_step("R3", 32'h0000_0000, 0, 0, 1);                 // wraps to 0

    for (int k = 0; k < 400; k++) begin
      logic [31:0] ins, a, b;
      int sel;
      sel = int'($urandom_range(0, 6));
      ins = $urandom;
      a = $urandom;
      b = ($urandom_range(0, 1) == 1) ? a : $urandom;
      case (sel)
        0: ins[31:26] = 6'd4;
        1: ins[31:26] = 6'd5;
        2: ins[31:26] = 6'd2;
        3: ins[31:26] = 6'd3;
        4: begin ins[31:26] = 6'd0; ins[5:0] = 6'd8; end
        5: ins[31:26] = 6'd0;
        default: ins[31:26] = 6'd35;
      endcase
      do_step("R10", ins, a, b, ($urandom_range(0, 7) != 0));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule